// File: doc/BRIEF.md
# Programmable Card Clock Selector

This block produces the clock for a smart card from a source clock. The card clock either runs at the source rate, at one half, one quarter or one eighth of it, or is parked at a fixed high or low level. A host sets it up through a small parallel programming port that is qualified by an active-low chip select. The port has a programming-mode select, two address lines and two data lines that together form a four-bit command.

The programming mode is latched when chip select falls. The command word is taken when chip select rises again. Commands either set a division ratio together with a card supply selection (3 V or 5 V), or start, stop-low or stop-high the card clock. The supply selection is only decoded and exported. A new setting never cuts a clock phase short. It waits for a fixed alignment point in the divider sequence, where every candidate output is low.

All logic runs on one system clock. The source clock and the port lines are sampled synchronously. The source clock must toggle no faster than every second system cycle.

Top module: `card_clk_sel`

## Requirements
- R1: After a synchronous active-low reset, card_clk is low, the card clock is stopped low, the ratio is divide-by-1 and vsel_5v is 0.
- R2: The programming flag is taken from prog_n (low = programming) at the clock edge that first samples cs_n low after high. prog_n may go high before cs_n rises without effect. A cycle whose flag was taken with prog_n high changes nothing.
- R3: The command word is {cmd_io, cmd_rst, addr[1], addr[0]}. It is taken only at the clock edge that first samples cs_n high after low, and the lines are ignored at all other times.
- R4: Codes 0 to 7 set the ratio to 2^(code[1:0]) and the supply selection to code[2] (1 = 5 V). vsel_5v takes the new value at the capturing edge. The ratio only becomes pending.
- R5: While running at ratio 1, card_clk repeats src_clk one cycle late. At ratio 2^r (r = 1..3), card_clk equals bit r-1 of the count of sampled src_clk rising edges modulo 8, registered in the cycle that sees the edge.
- R6: Code 8 runs the clock, code 9 stops it low and code 10 stops it high. The ratio is kept across a stop.
- R7: The pending ratio and run state take effect only at the edge that samples a src_clk falling edge while the rising-edge count modulo 8 is zero, and the latest command wins. No card_clk phase is shorter than half a src_clk period.
- R8: Codes 11 to 15 are ignored: the ratio, run state and supply selection are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select of the programming port |
| prog_n | input | 1 | Programming-mode select, low = programming |
| addr | input | 2 | Command bits 1:0 |
| cmd_rst | input | 1 | Command bit 2 |
| cmd_io | input | 1 | Command bit 3 |
| src_clk | input | 1 | Source clock, sampled by clk |
| card_clk | output | 1 | Card clock |
| vsel_5v | output | 1 | Decoded card supply selection, 1 = 5 V |

## Verification
Each result has a fixed latency:
- vsel_5v changes at the edge that first sees cs_n high.
- card_clk follows every sampled src_clk change one edge later.
- A new ratio or run state waits for the next alignment point, which can be up to eight src_clk periods away.

The bench keeps a behavioural model that counts source edges as an integer and applies pending settings at the same alignment point. Its outputs are compared with the design after every edge, so each result is checked in exactly the cycle it is due. Explicit checks after a settling wait, and a measured minimum phase length, cover the stop levels, the ignored codes and the absence of runt pulses.

// File: rtl/ccs_pkg.sv
// Shared constants and types for the card clock selector.
// Assumes at most a divide-by-8 chain and a four-bit command word.
package ccs_pkg;
    localparam int unsigned DIV_LOG2_MAX = 3;
    localparam int unsigned RATIO_W      = $clog2(DIV_LOG2_MAX + 1);
    localparam int unsigned CODE_W       = 4;

    localparam logic [CODE_W-1:0] CODE_RUN      = 4'd8;
    localparam logic [CODE_W-1:0] CODE_STOP_LO  = 4'd9;
    localparam logic [CODE_W-1:0] CODE_STOP_HI  = 4'd10;
    localparam logic [CODE_W-1:0] CODE_RSV_BASE = 4'd11;

    typedef enum logic [1:0] {
        RUN_ON      = 2'd0,
        RUN_STOP_LO = 2'd1,
        RUN_STOP_HI = 2'd2
    } run_e;

    typedef struct packed {
        run_e               run;
        logic [RATIO_W-1:0] ratio;
    } clk_cfg_t;
endpackage

// File: rtl/ccs_cmd_port.sv
// Programming port: latches the programming flag on chip-select fall and
// decodes the command word on chip-select rise into a target setting.
// Assumes all port lines are synchronous to clk.
module ccs_cmd_port
    import ccs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              prog_n,
    input  logic [CODE_W-1:0] code,
    output clk_cfg_t          tgt_cfg,
    output logic              vsel_5v,
    output logic              cmd_take
);
    logic cs_q;
    logic prog_held;
    logic cs_fall;
    logic cs_rise;

    assign cs_fall  = cs_q & ~cs_n;
    assign cs_rise  = ~cs_q & cs_n;
    assign cmd_take = cs_rise & prog_held;

    // Track chip select for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b1;
        else        cs_q <= cs_n;
    end

    // Hold the programming flag from the chip-select falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       prog_held <= 1'b0;
        else if (cs_fall) prog_held <= ~prog_n;
    end

    // Decode an accepted command into the target setting and supply select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_cfg.run   <= RUN_STOP_LO;
            tgt_cfg.ratio <= '0;
            vsel_5v       <= 1'b0;
        end else if (cmd_take) begin
            if (!code[CODE_W-1]) begin
                tgt_cfg.ratio <= code[RATIO_W-1:0];
                vsel_5v       <= code[RATIO_W];
            end else begin
                case (code)
                    CODE_RUN:     tgt_cfg.run <= RUN_ON;
                    CODE_STOP_LO: tgt_cfg.run <= RUN_STOP_LO;
                    CODE_STOP_HI: tgt_cfg.run <= RUN_STOP_HI;
                    default:      ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ccs_clk_gen.sv
// Divider and output stage: counts source rising edges, selects a tap,
// and adopts the target setting only at the aligned switch point.
// Assumes src_clk changes no faster than every second clk cycle.
module ccs_clk_gen
    import ccs_pkg::*;
#(
    parameter int unsigned STAGES = DIV_LOG2_MAX
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     src_clk,
    input  clk_cfg_t tgt_cfg,
    output clk_cfg_t act_cfg,
    output logic     card_clk
);
    logic              src_q;
    logic              src_rise;
    logic              src_fall;
    logic              sw_point;
    logic [STAGES-1:0] cnt;
    logic [STAGES-1:0] cnt_nx;
    logic [STAGES:0]   taps;
    clk_cfg_t          act_nx;
    logic              clk_nx;

    assign src_rise = src_clk & ~src_q;
    assign src_fall = ~src_clk & src_q;
    assign sw_point = src_fall & (cnt == '0);
    assign cnt_nx   = src_rise ? cnt + 1'b1 : cnt;
    assign act_nx   = sw_point ? tgt_cfg : act_cfg;

    // Tap 0 is the source itself; tap k is counter bit k-1.
    assign taps[0] = src_clk;
    for (genvar k = 1; k <= STAGES; k++) begin : g_tap
        assign taps[k] = cnt_nx[k-1];
    end

    // Choose the next card clock level from run state and ratio.
    always_comb begin
        case (act_nx.run)
            RUN_STOP_LO: clk_nx = 1'b0;
            RUN_STOP_HI: clk_nx = 1'b1;
            default:     clk_nx = taps[act_nx.ratio];
        endcase
    end

    // Register source sample, edge count, active setting and output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q         <= 1'b0;
            cnt           <= '0;
            act_cfg.run   <= RUN_STOP_LO;
            act_cfg.ratio <= '0;
            card_clk      <= 1'b0;
        end else begin
            src_q    <= src_clk;
            cnt      <= cnt_nx;
            act_cfg  <= act_nx;
            card_clk <= clk_nx;
        end
    end
endmodule

// File: rtl/card_clk_sel.sv
// Top of the card clock selector: programming port plus divider stage.
// Assumes a synchronous programming host and a sampled source clock.
module card_clk_sel
    import ccs_pkg::*;
#(
    parameter int unsigned STAGES = DIV_LOG2_MAX
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       prog_n,
    input  logic [1:0] addr,
    input  logic       cmd_rst,
    input  logic       cmd_io,
    input  logic       src_clk,
    output logic       card_clk,
    output logic       vsel_5v
);
    logic [CODE_W-1:0] cmd_code;
    logic              cmd_take;
    clk_cfg_t          tgt_cfg;
    clk_cfg_t          act_cfg;

    assign cmd_code = {cmd_io, cmd_rst, addr};

    ccs_cmd_port u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .prog_n   (prog_n),
        .code     (cmd_code),
        .tgt_cfg  (tgt_cfg),
        .vsel_5v  (vsel_5v),
        .cmd_take (cmd_take)
    );

    ccs_clk_gen #(.STAGES(STAGES)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_clk  (src_clk),
        .tgt_cfg  (tgt_cfg),
        .act_cfg  (act_cfg),
        .card_clk (card_clk)
    );
endmodule

// File: rtl/card_clk_sel_checker.sv
// Temporal properties of the card clock selector, bound into the top.
// Assumes the bound signals named in the bind statement below.
module card_clk_sel_checker
    import ccs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              src_clk,
    input logic              card_clk,
    input logic              vsel_5v,
    input logic              cmd_take,
    input logic [CODE_W-1:0] cmd_code,
    input clk_cfg_t          tgt_cfg,
    input clk_cfg_t          act_cfg
);
    logic [1:0] age;
    logic       age_ok;
    logic       was_rst;

    // Count cycles since reset so $past looks only at valid history.
    always_ff @(posedge clk) begin
        if (!rst_n)        age <= '0;
        else if (!age_ok)  age <= age + 1'b1;
    end
    assign age_ok = (age == 2'd3);

    // Remember that the previous edge was in reset.
    always_ff @(posedge clk) was_rst <= !rst_n;

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> (!card_clk && !vsel_5v));

    p_vsel_on_cs_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (age_ok && vsel_5v != $past(vsel_5v)) |-> ($past(cs_n) && !$past(cs_n, 2)));

    p_edge_follows_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age_ok && card_clk != $past(card_clk)) |-> ($past(src_clk) != $past(src_clk, 2)));

    p_stop_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (age_ok && act_cfg.run == RUN_STOP_LO && $past(act_cfg.run) == RUN_STOP_LO) |-> !card_clk);

    p_stop_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (age_ok && act_cfg.run == RUN_STOP_HI && $past(act_cfg.run) == RUN_STOP_HI) |-> card_clk);

    p_switch_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (age_ok && act_cfg != $past(act_cfg)) |-> (!$past(src_clk) && $past(src_clk, 2)));

    p_reserved_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_take && cmd_code >= CODE_RSV_BASE) |=> ($stable(tgt_cfg) && $stable(vsel_5v)));
endmodule

bind card_clk_sel card_clk_sel_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .src_clk  (src_clk),
    .card_clk (card_clk),
    .vsel_5v  (vsel_5v),
    .cmd_take (cmd_take),
    .cmd_code (cmd_code),
    .tgt_cfg  (tgt_cfg),
    .act_cfg  (act_cfg)
);

// File: tb/card_clk_sel_test.sv
// Bench: behavioural model compared every cycle plus targeted checks.
module card_clk_sel_test;
    localparam int SRC_HALF = 3;
    localparam int SETTLE   = 120;
    localparam int WD_LIMIT = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       prog_n = 1'b1;
    logic [1:0] addr = '0;
    logic       cmd_rst = 1'b0;
    logic       cmd_io = 1'b0;
    logic       src_clk = 1'b0;
    logic       card_clk;
    logic       vsel_5v;

    int    tests = 0;
    int    fails = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    bit    cmp_on = 1'b0;
    string cur_req = "R1";

    card_clk_sel uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .prog_n(prog_n),
        .addr(addr), .cmd_rst(cmd_rst), .cmd_io(cmd_io),
        .src_clk(src_clk), .card_clk(card_clk), .vsel_5v(vsel_5v)
    );

    always #10 clk = ~clk;

    // Source clock with a half period of SRC_HALF system cycles.
    int src_cnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            src_cnt = 0;
            src_clk = 1'b0;
        end else if (src_cnt == SRC_HALF - 1) begin
            src_cnt = 0;
            src_clk = ~src_clk;
        end else begin
            src_cnt = src_cnt + 1;
        end
    end

    // Behavioural reference model (run: 0 running, 1 stopped low, 2 stopped high).
    int m_rises, t_run, t_ratio, a_run, a_ratio;
    bit m_src_q, m_cs_q, m_prog, m_vsel, m_card;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_rises = 0; t_run = 1; t_ratio = 0; a_run = 1; a_ratio = 0;
            m_src_q = 0; m_cs_q = 1; m_prog = 0; m_vsel = 0; m_card = 0;
        end else begin
            int code;
            bit rise, fall;
            rise = src_clk && !m_src_q;
            fall = !src_clk && m_src_q;
            if (fall && (m_rises % 8) == 0) begin
                a_run = t_run;
                a_ratio = t_ratio;
            end
            if (rise) m_rises = m_rises + 1;
            if (a_run == 1)       m_card = 0;
            else if (a_run == 2)  m_card = 1;
            else if (a_ratio == 0) m_card = src_clk;
            else                  m_card = ((m_rises >> (a_ratio - 1)) & 1) != 0;
            m_src_q = src_clk;
            code = {cmd_io, cmd_rst, addr};
            if (m_cs_q && !cs_n) m_prog = !prog_n;
            if (!m_cs_q && cs_n && m_prog) begin
                if (code < 8) begin
                    t_ratio = code % 4;
                    m_vsel = (code / 4) % 2;
                end else if (code == 8)  t_run = 0;
                else if (code == 9)      t_run = 1;
                else if (code == 10)     t_run = 2;
            end
            m_cs_q = cs_n;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Cycle-by-cycle comparison against the model, sampled at the falling edge.
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            check(card_clk == m_card, {cur_req, " card_clk"}, card_clk, m_card);
            check(vsel_5v == m_vsel, {cur_req, " vsel_5v"}, vsel_5v, m_vsel);
        end
    end

    // Minimum card clock phase length, in system cycles (R7).
    int  ph_len = 0;
    int  ph_min = 1000;
    int  ph_cnt = 0;
    bit  last_card = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            ph_len = 0; ph_cnt = 0; last_card = 1'b0;
        end else if (card_clk !== last_card) begin
            if (ph_cnt > 0 && ph_len < ph_min) ph_min = ph_len;
            ph_cnt++;
            ph_len = 1;
            last_card = card_clk;
        end else begin
            ph_len++;
        end
    end

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WD_LIMIT);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One programming-port transaction: cs low, optional early prog release, cs high.
    task automatic send(input logic [3:0] code, input bit prog_low, input bit release_early);
        @(negedge clk);
        prog_n = !prog_low;
        {cmd_io, cmd_rst, addr} = code;
        idle(1);
        cs_n = 1'b0;
        idle(2);
        if (release_early) prog_n = 1'b1;
        idle(2);
        cs_n = 1'b1;
        idle(2);
        prog_n = 1'b1;
    endtask

    initial begin
        idle(5);
        check(card_clk == 1'b0, "R1 reset card_clk", card_clk, 0);
        check(vsel_5v == 1'b0, "R1 reset vsel_5v", vsel_5v, 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        idle(SETTLE);
        check(card_clk == 1'b0, "R1 stopped low after reset", card_clk, 0);

        cur_req = "R6 run";
        send(4'd8, 1, 0); idle(SETTLE);
        cur_req = "R5 ratio 2";
        send(4'd1, 1, 0); idle(SETTLE);
        cur_req = "R4 ratio 4 5V";
        send(4'd6, 1, 0);
        check(vsel_5v == 1'b1, "R4 vsel after capture", vsel_5v, 1);
        idle(SETTLE);
        cur_req = "R5 ratio 8";
        send(4'd7, 1, 0); idle(SETTLE);

        cur_req = "R6 stop high";
        send(4'd10, 1, 0); idle(SETTLE);
        check(card_clk == 1'b1, "R6 stopped high", card_clk, 1);

        cur_req = "R8 reserved";
        send(4'd13, 1, 0); idle(SETTLE);
        check(card_clk == 1'b1, "R8 still high after reserved", card_clk, 1);
        check(vsel_5v == 1'b1, "R8 vsel kept", vsel_5v, 1);
        send(4'd15, 1, 0); idle(SETTLE);
        check(card_clk == 1'b1, "R8 still high after code 15", card_clk, 1);

        cur_req = "R6 rerun keeps ratio";
        send(4'd8, 1, 0); idle(SETTLE);

        cur_req = "R2 not programming";
        send(4'd0, 0, 0); idle(SETTLE);
        check(vsel_5v == 1'b1, "R2 command without programming ignored", vsel_5v, 1);

        cur_req = "R2 early release";
        send(4'd4, 1, 1); idle(SETTLE);
        check(vsel_5v == 1'b1, "R2 early release accepted", vsel_5v, 1);

        cur_req = "R3 lines ignored while cs high";
        @(negedge clk);
        prog_n = 1'b0; {cmd_io, cmd_rst, addr} = 4'd2;
        idle(10);
        prog_n = 1'b1;
        idle(SETTLE);

        cur_req = "R7 latest wins";
        send(4'd5, 1, 0);
        send(4'd2, 1, 0);
        check(vsel_5v == 1'b0, "R7 second command vsel", vsel_5v, 0);
        idle(SETTLE);

        cur_req = "R6 stop low";
        send(4'd9, 1, 0); idle(SETTLE);
        check(card_clk == 1'b0, "R6 stopped low", card_clk, 0);
        cur_req = "R6 ratio while stopped";
        send(4'd3, 1, 0); idle(SETTLE);
        check(card_clk == 1'b0, "R6 ratio change keeps stop", card_clk, 0);
        send(4'd8, 1, 0); idle(SETTLE);

        check(ph_min >= SRC_HALF, "R7 minimum phase", ph_min, SRC_HALF);

        cmp_on = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule